// File: doc/BRIEF.md
# Instruction-Encoded Clock Phase Controller

This block sits beside the decode stage of a statically scheduled pipeline. It reads the four-bit timing nibble that occupies the top of each 32-bit instruction word and turns it into a clock phase code for a cycle-by-cycle phase-scaling clock generator. It also hands a reduced condition code to the execute stage. The phase code is registered. It therefore governs the cycle in which the decoded instruction occupies the next stage, one clock after decode.

Phase codes are three bits wide, in steps of 10% of the base period. Code k stretches the period by (k − 3) × 10%: code 3 is the base period, code 0 is −30% and code 7 (the safe code) is +40%. Three programmable tables hold the codes. An eight-entry table serves unconditional instructions, a two-entry table serves conditional ones and a four-entry table serves calibration.

In calibration mode, marked instructions run with trial codes. The block keeps the smallest code that an external checker has judged correct, and presents it on an output.

Top module: `instr_phase_ctl`

## Requirements
- R1: After reset, phaseCode is 7, condEn is 0, condSel is 0, calCycle is 0, calMin is 7, and every entry of all three tables holds 7.
- R2: In normal mode (calMode=0), a valid decode with field bit 0 = 0 makes phaseCode equal to wide-table entry field[3:1] on the next clock, with condEn=0, condSel=0 and calCycle=0.
- R3: In normal mode, a valid decode with field bit 0 = 1 makes phaseCode equal to narrow-table entry field[3] on the next clock, with condEn=1 and condSel=field[2:1]. The condSel encoding is 0 EQ, 1 NE, 2 GT, 3 LE.
- R4: In calibration mode, a valid decode with field[3]=1 and field[0]=0 makes phaseCode equal to calibration-table entry field[2:1] on the next clock, with calCycle=1 and condEn=0.
- R5: In calibration mode, a valid decode with field[3]=1 and field[0]=1 makes phaseCode equal to the value of extPhase sampled at decode, with calCycle=1, condEn=1 and condSel=field[2:1].
- R6: In calibration mode, a valid decode with field[3]=0 gives phaseCode=7 and calCycle=0 on the next clock. condEn equals field[0], and condSel is field[2:1] when condEn is 1 and 0 otherwise.
- R7: A cycle with decValid=0 gives phaseCode=7, condEn=0, condSel=0 and calCycle=0 on the next clock.
- R8: When cfgWe=1, cfgSel selects a table (0 wide, addressed by cfgAddr[2:0]; 1 narrow, addressed by cfgAddr[0]; 2 calibration, addressed by cfgAddr[1:0]) and cfgData is written into the addressed entry at the clock edge. cfgSel=3 writes nothing. A decode in the same cycle as a write reads the old entry.
- R9: In a cycle where calCycle=1 and calPass=1 and phaseCode < calMin, calMin takes the value of phaseCode on the next clock. Otherwise calMin keeps its value.
- R10: calPass has no effect on calMin in any cycle where calCycle=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | An instruction is in decode this cycle |
| decField | input | 4 | Top nibble of the instruction word (word bits 31:28) |
| calMode | input | 1 | Selects calibration mode |
| extPhase | input | PW | Externally supplied phase code for conditional calibration instructions |
| calPass | input | 1 | Correctness verdict for the cycle in which calCycle is high |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 2 | Table select for writes |
| cfgAddr | input | 3 | Table entry address |
| cfgData | input | PW | Phase code to write |
| phaseCode | output | PW | Registered phase code for the stage after decode |
| condEn | output | 1 | The instruction in that stage is conditional |
| condSel | output | 2 | Reduced condition code |
| calCycle | output | 1 | That stage is running a calibration trial |
| calMin | output | PW | Smallest code seen passing a calibration trial |

## Verification
Unconditional decodes sweep all eight wide-table indices, first with the reset contents and then with a ramp of distinct codes, so an index wired to the wrong field bits shows up as a wrong code. Conditional decodes cover both stretch bits and all four condition selects, which separates the narrow-table path from the condition pass-through. A calibration sequence feeds passing and failing trials at codes below, equal to and above the stored minimum. It also asserts calPass on a non-trial cycle that carries a small code, which separates a strict-compare and gated update from looser ones. A write to the same entry that is being decoded, a write with the unused select, and a long mixed random run check write timing and the interaction between modes.

// File: rtl/iphase_pkg.sv
package iphase_pkg;

  typedef enum logic [2:0] {
    SRC_SAFE,
    SRC_WIDE,
    SRC_NARROW,
    SRC_CAL,
    SRC_EXT
  } phaseSrc_e;

  // Bit positions inside the timing nibble (instruction bits 31:28)
  localparam int MODE_BIT = 0;
  localparam int SEL_LO   = 1;
  localparam int SEL_HI   = 2;
  localparam int TOP_BIT  = 3;

  typedef struct packed {
    logic       wrWide;
    logic       wrNarrow;
    logic       wrCal;
    phaseSrc_e  src;
    logic [2:0] idx;
    logic       condEn;
    logic [1:0] condSel;
    logic       calCycle;
  } decStrobe_t;

endpackage

// File: rtl/iphase_table.sv
module iphase_table #(
  parameter int DEPTH   = 8,
  parameter int PW      = 3,
  parameter int RST_VAL = 7,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [PW-1:0] wData,
  input  logic [AW-1:0] rAddr,
  output logic [PW-1:0] rData
);

  logic [PW-1:0] entries [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entries[i] <= PW'(RST_VAL);
    end else if (we) begin
      entries[wAddr] <= wData;
    end
  end

  assign rData = entries[rAddr];

endmodule

// File: rtl/iphase_ctrl.sv
module iphase_ctrl
  import iphase_pkg::*;
(
  input  logic       decValid,
  input  logic [3:0] decField,
  input  logic       calMode,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  output decStrobe_t strobe
);

  logic isCond;
  logic topBit;
  logic [1:0] selBits;

  assign isCond  = decField[MODE_BIT];
  assign topBit  = decField[TOP_BIT];
  assign selBits = decField[SEL_HI:SEL_LO];

  always_comb begin
    strobe          = '0;
    strobe.src      = SRC_SAFE;
    strobe.wrWide   = cfgWe && (cfgSel == 2'd0);
    strobe.wrNarrow = cfgWe && (cfgSel == 2'd1);
    strobe.wrCal    = cfgWe && (cfgSel == 2'd2);

    if (decValid) begin
      strobe.condEn  = isCond;
      strobe.condSel = isCond ? selBits : 2'd0;
      if (!calMode) begin
        if (isCond) begin
          strobe.src = SRC_NARROW;
          strobe.idx = {2'b00, topBit};
        end else begin
          strobe.src = SRC_WIDE;
          strobe.idx = {topBit, selBits};
        end
      end else if (topBit) begin
        strobe.calCycle = 1'b1;
        strobe.src      = isCond ? SRC_EXT : SRC_CAL;
        strobe.idx      = {1'b0, selBits};
      end
    end
  end

endmodule

// File: rtl/iphase_datapath.sv
module iphase_datapath
  import iphase_pkg::*;
#(
  parameter int PW = 3,
  localparam int WIDE_N    = 8,
  localparam int NARROW_N  = 2,
  localparam int CAL_N     = 4,
  localparam int WIDE_AW   = $clog2(WIDE_N),
  localparam int NARROW_AW = $clog2(NARROW_N),
  localparam int CAL_AW    = $clog2(CAL_N),
  localparam int SAFE_CODE = (1 << PW) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  decStrobe_t         strobe,
  input  logic [PW-1:0]      extPhase,
  input  logic               calPass,
  input  logic [WIDE_AW-1:0] cfgAddr,
  input  logic [PW-1:0]      cfgData,
  output logic [PW-1:0]      phaseCode,
  output logic               condEn,
  output logic [1:0]         condSel,
  output logic               calCycle,
  output logic [PW-1:0]      calMin
);

  logic [PW-1:0] wideRd, narrowRd, calRd, nextPhase;

  iphase_table #(.DEPTH(WIDE_N), .PW(PW), .RST_VAL(SAFE_CODE)) u_wide (
    .clk(clk), .rstN(rstN), .we(strobe.wrWide),
    .wAddr(cfgAddr), .wData(cfgData),
    .rAddr(strobe.idx[WIDE_AW-1:0]), .rData(wideRd)
  );

  iphase_table #(.DEPTH(NARROW_N), .PW(PW), .RST_VAL(SAFE_CODE)) u_narrow (
    .clk(clk), .rstN(rstN), .we(strobe.wrNarrow),
    .wAddr(cfgAddr[NARROW_AW-1:0]), .wData(cfgData),
    .rAddr(strobe.idx[NARROW_AW-1:0]), .rData(narrowRd)
  );

  iphase_table #(.DEPTH(CAL_N), .PW(PW), .RST_VAL(SAFE_CODE)) u_cal (
    .clk(clk), .rstN(rstN), .we(strobe.wrCal),
    .wAddr(cfgAddr[CAL_AW-1:0]), .wData(cfgData),
    .rAddr(strobe.idx[CAL_AW-1:0]), .rData(calRd)
  );

  always_comb begin
    unique case (strobe.src)
      SRC_WIDE:   nextPhase = wideRd;
      SRC_NARROW: nextPhase = narrowRd;
      SRC_CAL:    nextPhase = calRd;
      SRC_EXT:    nextPhase = extPhase;
      default:    nextPhase = PW'(SAFE_CODE);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCode <= PW'(SAFE_CODE);
      condEn    <= 1'b0;
      condSel   <= 2'd0;
      calCycle  <= 1'b0;
      calMin    <= PW'(SAFE_CODE);
    end else begin
      phaseCode <= nextPhase;
      condEn    <= strobe.condEn;
      condSel   <= strobe.condSel;
      calCycle  <= strobe.calCycle;
      if (calCycle && calPass && (phaseCode < calMin)) calMin <= phaseCode;
    end
  end

endmodule

// File: rtl/instr_phase_ctl.sv
module instr_phase_ctl
  import iphase_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          decValid,
  input  logic [3:0]    decField,
  input  logic          calMode,
  input  logic [PW-1:0] extPhase,
  input  logic          calPass,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [2:0]    cfgAddr,
  input  logic [PW-1:0] cfgData,
  output logic [PW-1:0] phaseCode,
  output logic          condEn,
  output logic [1:0]    condSel,
  output logic          calCycle,
  output logic [PW-1:0] calMin
);

  decStrobe_t strobe;

  iphase_ctrl u_ctrl (
    .decValid(decValid), .decField(decField), .calMode(calMode),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .strobe(strobe)
  );

  iphase_datapath #(.PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .extPhase(extPhase), .calPass(calPass),
    .cfgAddr(cfgAddr), .cfgData(cfgData),
    .phaseCode(phaseCode), .condEn(condEn), .condSel(condSel),
    .calCycle(calCycle), .calMin(calMin)
  );

endmodule

// File: rtl/instr_phase_ctl_chk.sv
module instr_phase_ctl_chk #(
  parameter int PW = 3,
  localparam int SAFE_CODE = (1 << PW) - 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          decValid,
  input logic [3:0]    decField,
  input logic          calMode,
  input logic          calPass,
  input logic [PW-1:0] phaseCode,
  input logic          condEn,
  input logic [1:0]    condSel,
  input logic          calCycle,
  input logic [PW-1:0] calMin
);

  p_bubble_safe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> (phaseCode == PW'(SAFE_CODE)) && !condEn && !calCycle);

  p_normal_no_trial_r2: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !calMode) |=> !calCycle);

  p_cond_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !calMode && decField[0]) |=> condEn && (condSel == $past(decField[2:1])));

  p_trial_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && calMode && decField[3]) |=> calCycle);

  p_nontrial_safe_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && calMode && !decField[3]) |=> (phaseCode == PW'(SAFE_CODE)) && !calCycle);

  p_min_update_r9: assert property (@(posedge clk) disable iff (!rstN)
    (calCycle && calPass && (phaseCode < calMin)) |=> calMin == $past(phaseCode));

  p_min_never_rises_r9: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> calMin <= $past(calMin));

  p_min_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(calCycle && calPass) |=> $stable(calMin));

endmodule

bind instr_phase_ctl instr_phase_ctl_chk #(.PW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .decField(decField),
  .calMode(calMode), .calPass(calPass), .phaseCode(phaseCode),
  .condEn(condEn), .condSel(condSel), .calCycle(calCycle), .calMin(calMin)
);

// File: tb/instr_phase_ctl_tb.sv
`timescale 1ns/100ps
module instr_phase_ctl_tb;

  localparam int PW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 1'b0;
  logic [3:0] decField = '0;
  logic calMode = 1'b0;
  logic [PW-1:0] extPhase = '0;
  logic calPass = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [2:0] cfgAddr = '0;
  logic [PW-1:0] cfgData = '0;
  logic [PW-1:0] phaseCode;
  logic condEn;
  logic [1:0] condSel;
  logic calCycle;
  logic [PW-1:0] calMin;

  instr_phase_ctl #(.PW(PW)) u_dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decField(decField),
    .calMode(calMode), .extPhase(extPhase), .calPass(calPass),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .phaseCode(phaseCode), .condEn(condEn), .condSel(condSel),
    .calCycle(calCycle), .calMin(calMin)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  int wideT[8]   = '{7, 7, 7, 7, 7, 7, 7, 7};
  int narrowT[2] = '{7, 7};
  int calT[4]    = '{7, 7, 7, 7};
  int expPhase = 7, expCondEn = 0, expCondSel = 0, expCal = 0, expMin = 7;
  bit anyWritten = 0;
  bit started = 0;
  string tag = "R1";
  string minTag = "R1";
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      foreach (wideT[i]) wideT[i] = 7;
      foreach (narrowT[i]) narrowT[i] = 7;
      foreach (calT[i]) calT[i] = 7;
      expPhase = 7; expCondEn = 0; expCondSel = 0; expCal = 0; expMin = 7;
      anyWritten = 0; tag = "R1"; minTag = "R1";
    end else begin
      if (expCal == 1 && calPass) begin
        if (expPhase < expMin) expMin = expPhase;
        minTag = "R9";
      end else if (calPass) minTag = "R10";
      else minTag = "R9";

      expCondEn = 0; expCondSel = 0; expCal = 0; expPhase = 7;
      if (!decValid) tag = "R7";
      else if (!calMode) begin
        if (!decField[0]) begin
          expPhase = wideT[decField[3:1]];
          tag = anyWritten ? "R2 R8" : "R2 R1";
        end else begin
          expPhase = narrowT[decField[3]];
          expCondEn = 1; expCondSel = decField[2:1];
          tag = anyWritten ? "R3 R8" : "R3 R1";
        end
      end else begin
        expCondEn = decField[0];
        expCondSel = decField[0] ? decField[2:1] : 0;
        if (decField[3]) begin
          expCal = 1;
          if (decField[0]) begin
            expPhase = extPhase; tag = "R5";
          end else begin
            expPhase = calT[decField[2:1]];
            tag = anyWritten ? "R4 R8" : "R4 R1";
          end
        end else tag = "R6";
      end

      if (cfgWe) begin
        case (cfgSel)
          2'd0: begin wideT[cfgAddr] = cfgData; anyWritten = 1; end
          2'd1: begin narrowT[cfgAddr[0]] = cfgData; anyWritten = 1; end
          2'd2: begin calT[cfgAddr[1:0]] = cfgData; anyWritten = 1; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp, input string t);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("phaseCode", int'(phaseCode), expPhase, tag);
      chk("condEn", int'(condEn), expCondEn, tag);
      chk("condSel", int'(condSel), expCondSel, tag);
      chk("calCycle", int'(calCycle), expCal, tag);
      chk("calMin", int'(calMin), expMin, minTag);
    end
  end

  task automatic drive(input logic v, input logic [3:0] f, input logic cm,
                       input logic [2:0] ext, input logic pass, input logic we,
                       input logic [1:0] s, input logic [2:0] a, input logic [2:0] d);
    @(negedge clk);
    decValid = v; decField = f; calMode = cm; extPhase = ext; calPass = pass;
    cfgWe = we; cfgSel = s; cfgAddr = a; cfgData = d;
  endtask

  task automatic dec(input logic [3:0] f, input logic cm, input logic [2:0] ext, input logic pass);
    drive(1'b1, f, cm, ext, pass, 1'b0, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic wr(input logic [1:0] s, input logic [2:0] a, input logic [2:0] d);
    drive(1'b0, 4'd0, 1'b0, 3'd0, 1'b0, 1'b1, s, a, d);
  endtask

  task automatic bubble(input logic pass);
    drive(1'b0, 4'd0, 1'b0, 3'd0, pass, 1'b0, 2'd0, 3'd0, 3'd0);
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    bubble(1'b0);

    // R2/R3 with reset table contents (all safe code)
    for (int i = 0; i < 8; i++) dec({i[2:0], 1'b0}, 1'b0, 3'd0, 1'b0);
    dec(4'b1011, 1'b0, 3'd0, 1'b0);

    // R8: program tables
    for (int i = 0; i < 8; i++) wr(2'd0, i[2:0], i[2:0]);
    wr(2'd1, 3'd0, 3'd3);
    wr(2'd1, 3'd1, 3'd7);
    wr(2'd2, 3'd0, 3'd0);
    wr(2'd2, 3'd1, 3'd1);
    wr(2'd2, 3'd2, 3'd2);
    wr(2'd2, 3'd3, 3'd2);
    wr(2'd3, 3'd0, 3'd5);   // ignored select
    dec(4'b0000, 1'b0, 3'd0, 1'b0);
    dec(4'b0001, 1'b0, 3'd0, 1'b0);

    // R2: all wide indices, with bubbles (R7) between some
    for (int i = 0; i < 8; i++) begin
      dec({i[2:0], 1'b0}, 1'b0, 3'd0, 1'b0);
      if (i % 3 == 0) bubble(1'b0);
    end
    // R3: both stretch bits, all condition selects
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 4; c++) dec({b[0], c[1:0], 1'b1}, 1'b0, 3'd0, 1'b0);

    // R8: same-cycle write and decode of one entry reads old value
    drive(1'b1, 4'b1010, 1'b0, 3'd0, 1'b0, 1'b1, 2'd0, 3'd5, 3'd2);
    dec(4'b1010, 1'b0, 3'd0, 1'b0);

    // R10: calPass while a small non-trial code is in the stage
    dec(4'b0000, 1'b0, 3'd0, 1'b0);
    dec(4'b0010, 1'b0, 3'd0, 1'b1);
    bubble(1'b1);

    // R4/R9: calibration trials
    dec(4'b1110, 1'b1, 3'd0, 1'b0);   // code 2
    dec(4'b1010, 1'b1, 3'd0, 1'b1);   // pass on code 2 -> min 2 ; issue code 1
    dec(4'b1100, 1'b1, 3'd0, 1'b0);   // code 1 fails ; issue code 2
    dec(4'b0000, 1'b1, 3'd0, 1'b1);   // code 2 passes, not smaller ; R6 non-trial
    dec(4'b1011, 1'b1, 3'd1, 1'b1);   // R5 ext code 1 ; pass on non-trial ignored
    dec(4'b0111, 1'b1, 3'd0, 1'b1);   // ext code 1 passes -> min 1 ; R6 conditional
    dec(4'b1000, 1'b1, 3'd0, 1'b0);   // code 0 trial
    bubble(1'b1);                     // code 0 passes -> min 0
    bubble(1'b0);

    // Back to reset check after activity (R1)
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    dec(4'b0110, 1'b0, 3'd0, 1'b0);

    // Mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] | r[1], r[5:2], r[6] & r[7], r[10:8], r[11],
            r[12] & r[13] & r[14], r[16:15], r[19:17], r[22:20]);
    end
    bubble(1'b0);
    bubble(1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule